// File: doc/BRIEF.md
# Received Message Classifier and Filter

This block sits in a packet receive path and looks at one 128-bit message header per transfer. It sorts each header into one of four outcomes: an error event, a forward to the user port, an Unsupported Request report, or a silent discard. Error messages of the three severities raise a one-cycle event. The event carries a severity code and the requester ID of the agent that detected the fault. The host side then turns that event into a system-level notification.

Vendor-defined messages are filtered by their vendor ID, which is compared against a small programmable table of supported IDs. Each table entry has its own enable bit. A vendor message whose ID is in the table is forwarded, whether or not it carries data. When the ID is not in the table, the message subtype decides the result: subtype 1 is dropped without any trace, and subtype 0 raises an Unsupported Request pulse.

Headers enter on a valid/ready stream, and a transfer takes place on any cycle where `hdr_valid` and `hdr_ready` are both high. The forward output is also valid/ready. Once `fwd_valid` is high, it stays high with a stable header until `fwd_ready` is seen. While the forward output is held, `hdr_ready` stays low, so back-pressure reaches the input and no header is lost. The error and Unsupported Request outputs are plain one-cycle pulses and cannot push back. The payload that follows a header is handled outside this block.

Top module: `msgc_top`

## Requirements
- R1: While reset is asserted and after it is released, `err_valid`, `ur_valid` and `fwd_valid` are low and `hdr_ready` is high.
- R2: A header is taken when `hdr_valid` and `hdr_ready` are both high. `hdr_ready` is low only while `fwd_valid` is high and `fwd_ready` is low, and a header offered during that time produces no result.
- R3: A message header has Fmt (bits 127:125) equal to 001 and Type bits 124:123 equal to 10. If its message code (byte 7, bits 71:64) is 0x30, 0x31 or 0x33, `err_valid` pulses in the cycle after acceptance. `err_sev` is then 0, 1 or 2 respectively, and `err_rid` equals header bytes 4–5 (bits 95:80).
- R4: No output is raised for a header that is not a message (Type bits 124:123 not 10, or Fmt not 001/011), or that has message code 0x32, or that has an error code with Fmt 011.
- R5: A table write (`tbl_we` high) stores `tbl_vid` and the enable `tbl_en` at entry `tbl_idx`. The write applies to headers accepted in later cycles.
- R6: A vendor message (code 0x7E or 0x7F, Fmt 001 or 011) whose vendor ID (bytes 10–11, bits 47:32) matches an enabled table entry raises `fwd_valid` in the cycle after acceptance. `fwd_hdr` then equals the whole header, and `fwd_with_data` is high exactly when Fmt is 011.
- R7: A code-0x7F vendor message with no matching enabled entry raises no output.
- R8: A code-0x7E vendor message with no matching enabled entry pulses `ur_valid` in the cycle after acceptance, and `ur_rid` equals header bytes 4–5.
- R9: `err_valid` and `ur_valid` last one cycle per accepted header and are never high together. While `fwd_ready` is low, `fwd_valid` and `fwd_hdr` hold their values.
- R10: An entry whose enable bit is 0 never matches, even if its stored ID equals the vendor ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be taken |
| hdr_data | input | 128 | Header, byte 0 in bits 127:120 |
| tbl_we | input | 1 | Write one vendor table entry |
| tbl_idx | input | TBL_IDX_W | Entry index to write |
| tbl_vid | input | 16 | Vendor ID to store |
| tbl_en | input | 1 | Enable bit to store |
| err_valid | output | 1 | Error event pulse |
| err_sev | output | 2 | 0 correctable, 1 non-fatal, 2 fatal |
| err_rid | output | 16 | Requester ID of the reporting agent |
| ur_valid | output | 1 | Unsupported Request pulse |
| ur_rid | output | 16 | Requester ID of the unsupported message |
| fwd_valid | output | 1 | Forwarded vendor header available |
| fwd_ready | input | 1 | User port takes the forwarded header |
| fwd_hdr | output | 128 | Forwarded header |
| fwd_with_data | output | 1 | Forwarded message carries a payload |

## Verification
The classification is exercised with a set of headers chosen so that each differs from another in one field only. The three error codes are tested next to the unused code 0x32, to an error code carrying data and to a non-message header that happens to have 0x30 at byte 7, which shows that the code, Fmt and Type fields are all decoded. Both vendor subtypes are sent with a listed ID, an unlisted ID and a listed-but-disabled ID, which separates forward, drop and Unsupported Request and shows that the enable bit matters. Directed sequences then stall the forward port while an error header waits, and rewrite the table between two identical headers to show that writes take effect.

// File: rtl/msgc_pkg.sv
package msgc_pkg;
  localparam int HDR_W = 128;
  localparam int ID_W  = 16;

  // field positions (byte 0 in the top bits)
  localparam int FMT_MSB  = HDR_W - 1;
  localparam int TYP_MSB  = HDR_W - 4;
  localparam int RID_LSB  = HDR_W - 48;
  localparam int CODE_LSB = HDR_W - 64;
  localparam int VID_LSB  = HDR_W - 96;

  localparam logic [2:0] FMT_NODATA = 3'b001;
  localparam logic [2:0] FMT_DATA   = 3'b011;
  localparam logic [1:0] MSG_GROUP  = 2'b10;

  localparam logic [7:0] CODE_COR   = 8'h30;
  localparam logic [7:0] CODE_NONF  = 8'h31;
  localparam logic [7:0] CODE_FATAL = 8'h33;
  localparam logic [7:0] CODE_VEND0 = 8'h7E;
  localparam logic [7:0] CODE_VEND1 = 8'h7F;

  typedef enum logic [1:0] {
    SEV_COR   = 2'd0,
    SEV_NONF  = 2'd1,
    SEV_FATAL = 2'd2
  } sev_e;

  typedef enum logic [2:0] {
    RES_NONE,
    RES_ERR,
    RES_FWD,
    RES_UR,
    RES_DROP
  } res_e;
endpackage

// File: rtl/msgc_vid_table.sv
module msgc_vid_table
  import msgc_pkg::*;
#(
  parameter int NUM   = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [ID_W-1:0]  id_in,
  input  logic             en_in,
  input  logic [ID_W-1:0]  lookup,
  output logic             hit
);
  logic [ID_W-1:0] ent_id [NUM];
  logic [NUM-1:0]  ent_en;
  logic [NUM-1:0]  match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) ent_id[i] <= '0;
      ent_en <= '0;
    end else if (we) begin
      ent_id[idx] <= id_in;
      ent_en[idx] <= en_in;
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign match[g] = ent_en[g] && (ent_id[g] == lookup);
  end

  assign hit = |match;

  // R5
  tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ent_en[$past(idx)] == $past(en_in)) && (ent_id[$past(idx)] == $past(id_in)));
endmodule

// File: rtl/msgc_decode.sv
module msgc_decode
  import msgc_pkg::*;
(
  input  logic [2:0] fmt,
  input  logic [1:0] grp,
  input  logic [7:0] code,
  input  logic       vid_hit,
  output res_e       res,
  output logic [1:0] sev,
  output logic       with_data
);
  logic is_msg;
  logic no_data;

  assign no_data   = (fmt == FMT_NODATA);
  assign with_data = (fmt == FMT_DATA);
  assign is_msg    = (grp == MSG_GROUP) && (no_data || with_data);

  always_comb begin
    res = RES_NONE;
    sev = SEV_COR;
    if (is_msg) begin
      case (code)
        CODE_COR: begin
          if (no_data) res = RES_ERR;
          sev = SEV_COR;
        end
        CODE_NONF: begin
          if (no_data) res = RES_ERR;
          sev = SEV_NONF;
        end
        CODE_FATAL: begin
          if (no_data) res = RES_ERR;
          sev = SEV_FATAL;
        end
        CODE_VEND0: res = vid_hit ? RES_FWD : RES_UR;
        CODE_VEND1: res = vid_hit ? RES_FWD : RES_DROP;
        default:    res = RES_NONE;
      endcase
    end
  end
endmodule

// File: rtl/msgc_out_stage.sv
module msgc_out_stage
  import msgc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  res_e             res,
  input  logic [1:0]       sev,
  input  logic [ID_W-1:0]  rid,
  input  logic [HDR_W-1:0] hdr,
  input  logic             with_data,
  input  logic             fwd_ready,
  output logic             err_valid,
  output logic [1:0]       err_sev,
  output logic [ID_W-1:0]  err_rid,
  output logic             ur_valid,
  output logic [ID_W-1:0]  ur_rid,
  output logic             fwd_valid,
  output logic [HDR_W-1:0] fwd_hdr,
  output logic             fwd_with_data
);
  logic take_err, take_ur, take_fwd;

  assign take_err = accept && (res == RES_ERR);
  assign take_ur  = accept && (res == RES_UR);
  assign take_fwd = accept && (res == RES_FWD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid     <= 1'b0;
      err_sev       <= '0;
      err_rid       <= '0;
      ur_valid      <= 1'b0;
      ur_rid        <= '0;
      fwd_valid     <= 1'b0;
      fwd_hdr       <= '0;
      fwd_with_data <= 1'b0;
    end else begin
      err_valid <= take_err;
      ur_valid  <= take_ur;
      if (take_err) begin
        err_sev <= sev;
        err_rid <= rid;
      end
      if (take_ur) ur_rid <= rid;
      if (take_fwd) begin
        fwd_valid     <= 1'b1;
        fwd_hdr       <= hdr;
        fwd_with_data <= with_data;
      end else if (fwd_ready) begin
        fwd_valid <= 1'b0;
      end
    end
  end

  // R9
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_hdr)));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_valid, ur_valid}));

  // R2
  no_stall_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !(fwd_valid && !fwd_ready));

  // R6
  fwd_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_with_data == (fwd_hdr[HDR_W-1 -: 3] == FMT_DATA)));

  // R3
  err_sev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_sev != 2'd3));
endmodule

// File: rtl/msgc_top.sv
module msgc_top
  import msgc_pkg::*;
#(
  parameter int NUM_VID   = 4,
  parameter int TBL_IDX_W = (NUM_VID > 1) ? $clog2(NUM_VID) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hdr_valid,
  output logic                 hdr_ready,
  input  logic [127:0]         hdr_data,
  input  logic                 tbl_we,
  input  logic [TBL_IDX_W-1:0] tbl_idx,
  input  logic [15:0]          tbl_vid,
  input  logic                 tbl_en,
  output logic                 err_valid,
  output logic [1:0]           err_sev,
  output logic [15:0]          err_rid,
  output logic                 ur_valid,
  output logic [15:0]          ur_rid,
  output logic                 fwd_valid,
  input  logic                 fwd_ready,
  output logic [127:0]         fwd_hdr,
  output logic                 fwd_with_data
);
  logic [2:0]      f_fmt;
  logic [1:0]      f_grp;
  logic [7:0]      f_code;
  logic [ID_W-1:0] f_rid;
  logic [ID_W-1:0] f_vid;
  logic            vid_hit;
  res_e            res;
  logic [1:0]      sev;
  logic            with_data;
  logic            accept;

  assign f_fmt  = hdr_data[FMT_MSB -: 3];
  assign f_grp  = hdr_data[TYP_MSB -: 2];
  assign f_code = hdr_data[CODE_LSB +: 8];
  assign f_rid  = hdr_data[RID_LSB +: ID_W];
  assign f_vid  = hdr_data[VID_LSB +: ID_W];

  assign hdr_ready = !fwd_valid || fwd_ready;
  assign accept    = hdr_valid && hdr_ready;

  msgc_vid_table #(.NUM(NUM_VID), .IDX_W(TBL_IDX_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we),
    .idx    (tbl_idx),
    .id_in  (tbl_vid),
    .en_in  (tbl_en),
    .lookup (f_vid),
    .hit    (vid_hit)
  );

  msgc_decode u_decode (
    .fmt       (f_fmt),
    .grp       (f_grp),
    .code      (f_code),
    .vid_hit   (vid_hit),
    .res       (res),
    .sev       (sev),
    .with_data (with_data)
  );

  msgc_out_stage u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .res           (res),
    .sev           (sev),
    .rid           (f_rid),
    .hdr           (hdr_data),
    .with_data     (with_data),
    .fwd_ready     (fwd_ready),
    .err_valid     (err_valid),
    .err_sev       (err_sev),
    .err_rid       (err_rid),
    .ur_valid      (ur_valid),
    .ur_rid        (ur_rid),
    .fwd_valid     (fwd_valid),
    .fwd_hdr       (fwd_hdr),
    .fwd_with_data (fwd_with_data)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!err_valid && !ur_valid && !fwd_valid));
endmodule

// File: tb/test_msgc_top.sv
module test_msgc_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hdr_valid = 1'b0;
  logic         hdr_ready;
  logic [127:0] hdr_data = '0;
  logic         tbl_we = 1'b0;
  logic [1:0]   tbl_idx = '0;
  logic [15:0]  tbl_vid = '0;
  logic         tbl_en = 1'b0;
  logic         err_valid;
  logic [1:0]   err_sev;
  logic [15:0]  err_rid;
  logic         ur_valid;
  logic [15:0]  ur_rid;
  logic         fwd_valid;
  logic         fwd_ready = 1'b1;
  logic [127:0] fwd_hdr;
  logic         fwd_with_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  msgc_top i_msgc_top (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_vid(tbl_vid),
    .tbl_en(tbl_en), .err_valid(err_valid), .err_sev(err_sev), .err_rid(err_rid),
    .ur_valid(ur_valid), .ur_rid(ur_rid), .fwd_valid(fwd_valid),
    .fwd_ready(fwd_ready), .fwd_hdr(fwd_hdr), .fwd_with_data(fwd_with_data)
  );

  // vector: fmt(3) type(5) code(8) rid(16) vid(16) exp_kind(2) exp_sev(2) exp_wd(1)
  // exp_kind: 0 nothing, 1 error event, 2 forward, 3 unsupported request
  localparam int NV = 13;
  localparam logic [52:0] VEC [NV] = '{
    {3'b001, 5'b10000, 8'h30, 16'h0101, 16'h0000, 2'd1, 2'd0, 1'b0}, // R3 cor
    {3'b001, 5'b10000, 8'h31, 16'h0202, 16'h0000, 2'd1, 2'd1, 1'b0}, // R3 nonfatal
    {3'b001, 5'b10000, 8'h33, 16'hF00D, 16'h0000, 2'd1, 2'd2, 1'b0}, // R3 fatal
    {3'b001, 5'b10000, 8'h32, 16'h0303, 16'h0000, 2'd0, 2'd0, 1'b0}, // R4 code gap
    {3'b011, 5'b10000, 8'h30, 16'h0404, 16'h0000, 2'd0, 2'd0, 1'b0}, // R4 error with data
    {3'b010, 5'b00000, 8'h30, 16'h0505, 16'h0000, 2'd0, 2'd0, 1'b0}, // R4 not a message
    {3'b001, 5'b10100, 8'h7E, 16'h0A0A, 16'h1AB3, 2'd2, 2'd0, 1'b0}, // R6 type0 listed
    {3'b011, 5'b10010, 8'h7F, 16'h0B0B, 16'hBEEF, 2'd2, 2'd0, 1'b1}, // R6 type1 listed data
    {3'b001, 5'b10100, 8'h7E, 16'h0C0C, 16'h4444, 2'd3, 2'd0, 1'b0}, // R8 type0 unlisted
    {3'b011, 5'b10100, 8'h7F, 16'h0E0E, 16'h4444, 2'd0, 2'd0, 1'b0}, // R7 type1 unlisted
    {3'b001, 5'b10100, 8'h7E, 16'h0D0D, 16'h3333, 2'd3, 2'd0, 1'b0}, // R10 disabled type0
    {3'b001, 5'b10100, 8'h7F, 16'h0F0F, 16'h3333, 2'd0, 2'd0, 1'b0}, // R10 disabled type1
    {3'b011, 5'b10000, 8'h7E, 16'h1111, 16'h2222, 2'd2, 2'd0, 1'b1}  // R6 type0 data
  };

  function automatic logic [127:0] mk(input logic [2:0] f, input logic [4:0] t,
                                      input logic [7:0] c, input logic [15:0] r,
                                      input logic [15:0] v);
    logic [127:0] h = '0;
    h[127:125] = f;
    h[124:120] = t;
    h[95:80]   = r;
    h[71:64]   = c;
    h[47:32]   = v;
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_tbl(input logic [1:0] i, input logic [15:0] v, input logic e);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = i; tbl_vid = v; tbl_en = e;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // offer one header for one cycle; returns at the negedge after acceptance
  task automatic send(input logic [127:0] h);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_data = h;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] h;
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(!err_valid && !ur_valid && !fwd_valid, "R1 outputs in reset",
        {err_valid, ur_valid, fwd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hdr_ready && !err_valid && !ur_valid && !fwd_valid, "R1 idle after reset",
        {hdr_ready, err_valid, ur_valid, fwd_valid}, 128'h8);

    // R5: program table
    wr_tbl(2'd0, 16'h1AB3, 1'b1);
    wr_tbl(2'd1, 16'h2222, 1'b1);
    wr_tbl(2'd2, 16'h3333, 1'b0);
    wr_tbl(2'd3, 16'hBEEF, 1'b1);

    for (int k = 0; k < NV; k++) begin
      logic [1:0] ek;
      ek = VEC[k][4:3];
      h  = mk(VEC[k][52:50], VEC[k][49:45], VEC[k][44:37], VEC[k][36:21], VEC[k][20:5]);
      send(h);
      chk({err_valid, fwd_valid, ur_valid} == {ek == 2'd1, ek == 2'd2, ek == 2'd3},
          $sformatf("R3/R4/R6/R7/R8/R10 kind vec%0d", k),
          {err_valid, fwd_valid, ur_valid}, {ek == 2'd1, ek == 2'd2, ek == 2'd3});
      if (ek == 2'd1)
        chk(err_sev == VEC[k][2:1] && err_rid == VEC[k][36:21],
            $sformatf("R3 sev/rid vec%0d", k), {err_sev, err_rid}, {VEC[k][2:1], VEC[k][36:21]});
      if (ek == 2'd2)
        chk(fwd_hdr == h && fwd_with_data == VEC[k][0],
            $sformatf("R6 hdr/data vec%0d", k), {fwd_with_data, fwd_hdr[126:0]},
            {VEC[k][0], h[126:0]});
      if (ek == 2'd3)
        chk(ur_rid == VEC[k][36:21], $sformatf("R8 rid vec%0d", k), ur_rid, VEC[k][36:21]);
      @(negedge clk);
      // R9: pulses gone one cycle later
      chk(!err_valid && !ur_valid && !fwd_valid, $sformatf("R9 single pulse vec%0d", k),
          {err_valid, ur_valid, fwd_valid}, 0);
    end

    // R2 / R9: back-pressure on the forward port
    fwd_ready = 1'b0;
    held = mk(3'b001, 5'b10100, 8'h7E, 16'h5A5A, 16'h2222);
    send(held);
    chk(fwd_valid && !hdr_ready, "R2 stall raises back-pressure",
        {fwd_valid, hdr_ready}, 2'b10);
    @(negedge clk);
    hdr_valid = 1'b1;
    hdr_data  = mk(3'b001, 5'b10000, 8'h33, 16'h7777, 16'h0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(fwd_valid && fwd_hdr == held && !err_valid && !hdr_ready,
          "R9/R2 held while stalled", {fwd_valid, err_valid, hdr_ready, fwd_hdr[124:0]},
          {3'b100, held[124:0]});
    end
    fwd_ready = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk(!fwd_valid && err_valid && err_sev == 2'd2 && err_rid == 16'h7777,
        "R2 waiting header taken on release", {fwd_valid, err_valid, err_sev, err_rid},
        {2'b01, 2'd2, 16'h7777});

    // R5: rewrite table between identical headers
    h = mk(3'b001, 5'b10100, 8'h7E, 16'h6161, 16'h1AB3);
    wr_tbl(2'd0, 16'h1AB3, 1'b0);
    send(h);
    chk(ur_valid && !fwd_valid && ur_rid == 16'h6161, "R5 disabled entry gives UR",
        {ur_valid, fwd_valid, ur_rid}, {2'b10, 16'h6161});
    wr_tbl(2'd2, 16'h1AB3, 1'b1);
    send(h);
    chk(fwd_valid && !ur_valid && fwd_hdr == h, "R5 new entry forwards",
        {fwd_valid, ur_valid, fwd_hdr[125:0]}, {2'b10, h[125:0]});
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule